// File: doc/BRIEF.md
# Reset Cause Tracker and Release Sequencer

This block collects reset requests from nine causes (power-on, brown-out, external pin, watchdog timeout, software reset, illegal opcode, uninitialized register access, trap conflict and configuration mismatch). It records each cause in a sticky flag. It also drives a system reset output that is held for a number of clock cycles fixed by the kind of reset. That time is built from up to three back-to-back segments:

- a power-on segment,
- a start-up segment,
- an internal-state segment.

Power-on resets run all three segments. Brown-out resets skip the first segment. Every other cause runs only the last segment.

Software reads the flag register and may overwrite it at any time. Writing to it never starts a reset. Three event pulses also act on the flags: sleep entry, idle entry and watchdog clear. A further output tells the clock logic whether the most recent reset should take the system clock from the configuration bits or keep the current selection.

Top module: `rst_cause_seq`

## Requirements
- R1: While `rst_n` is low, and after it rises, the block behaves as if a power-on had just occurred. The flag register reads 0x001, `clk_from_cfg` is 1, and `sys_rst` stays high for POR_CYCLES+START_CYCLES+INT_CYCLES cycles counted from the release.
- R2: A power-on request (`req_i[0]`) sampled at a clock edge raises `sys_rst` after that edge. `sys_rst` stays high for POR_CYCLES+START_CYCLES+INT_CYCLES cycles.
- R3: A brown-out request (`req_i[1]`) holds `sys_rst` high for START_CYCLES+INT_CYCLES cycles.
- R4: A request on any of `req_i[8:2]` holds `sys_rst` high for INT_CYCLES cycles. These are pin, watchdog, software, illegal opcode, uninitialized register, trap conflict and configuration mismatch.
- R5: When several requests arrive in the same cycle, the longest sequence wins. Power-on beats brown-out, and brown-out beats the rest.
- R6: A request sampled while `sys_rst` is high restarts the delay at the first segment of the new request's type, even if that makes the total shorter. A request held high reloads that segment on every cycle it stays high.
- R7: Each request sets its own flag in the next cycle. Flag bit positions are:
  - 0 power-on, 1 brown-out, 2 pin,
  - 3 watchdog, 4 software, 5 illegal opcode,
  - 6 uninitialized register, 7 trap conflict, 8 configuration mismatch,
  - 9 sleep, 10 idle.
- R8: A power-on request clears flags 2 to 10. A brown-out request clears flags 3 to 10 and leaves the pin flag (bit 2) alone. Neither request clears flag 0 or flag 1.
- R9: A sleep event sets flag 9 and an idle event sets flag 10. A sleep, idle or watchdog-clear event clears the watchdog flag (bit 3) unless a watchdog request arrives in the same cycle.
- R10: When `reg_we` is high, the flags load `reg_wdata`. Hardware clears and then hardware sets from the same cycle are applied on top of the written value. A write never raises `sys_rst`. `reg_rdata` always shows the flags.
- R11: Each request updates `clk_from_cfg`. The output becomes 1 if `clk_switch_en` is 0 or a power-on or brown-out request is among the requests; otherwise it becomes 0. Between requests the value is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, treated as a power-on |
| req_i | input | 9 | Reset requests, one bit per cause (positions as in R7) |
| sleep_evt | input | 1 | Sleep entry pulse |
| idle_evt | input | 1 | Idle entry pulse |
| wdt_clr_evt | input | 1 | Watchdog clear pulse |
| clk_switch_en | input | 1 | Clock switching enabled |
| reg_we | input | 1 | Flag register write strobe |
| reg_wdata | input | 11 | Flag register write data |
| reg_rdata | output | 11 | Flag register contents |
| sys_rst | output | 1 | System reset, active high |
| clk_from_cfg | output | 1 | 1: take clock from configuration bits after this reset |

## Verification
The bench measures the length of every `sys_rst` pulse. It aims at pulses that are restarted mid-sequence by a different cause, and at requests that are held for several cycles. A sequencer that ignored new requests would give a 4-cycle pulse where 13 are expected. One that resumed from its current segment instead of restarting would give the wrong length in both cases. The bench also targets flag-clearing overlaps. A brown-out must keep the pin flag, which a design sharing one clear mask for power-on and brown-out would lose. A sleep event in the same cycle as a software write must still leave the sleep flag set; if the write won, the flag would come back clear. The remaining probes are a software write that should do nothing to `sys_rst`, and combined power-on-plus-pin and brown-out-plus-watchdog requests, which a wrong priority would shorten.

// File: rtl/rcs_pkg.sv
// Shared constants and types for the reset cause tracker.
// Assumes: flag positions 0..8 match request positions; 9 and 10 are sleep and idle.
package rcs_pkg;
    localparam int NCAUSE = 9;
    localparam int NFLAG  = 11;

    localparam int F_POR    = 0;
    localparam int F_BOR    = 1;
    localparam int F_PIN    = 2;
    localparam int F_WDT    = 3;
    localparam int F_SWR    = 4;
    localparam int F_ILLOP  = 5;
    localparam int F_UNINIT = 6;
    localparam int F_TRAPC  = 7;
    localparam int F_CFGMM  = 8;
    localparam int F_SLEEP  = 9;
    localparam int F_IDLE   = 10;

    // Flags wiped by a power-on: everything except the two supply flags.
    localparam logic [NFLAG-1:0] POR_CLR_MASK = 11'b111_1111_1100;
    // Flags wiped by a brown-out: as above, but the pin flag survives.
    localparam logic [NFLAG-1:0] BOR_CLR_MASK = 11'b111_1111_1000;

    typedef enum logic [1:0] {
        PH_RUN   = 2'd0,
        PH_POR   = 2'd1,
        PH_START = 2'd2,
        PH_INT   = 2'd3
    } phase_e;
endpackage

// File: rtl/rcs_req_class.sv
// Classifies the request vector into the delay class to start and the
// clock selection that follows it. Purely combinational.
// Assumes: power-on outranks brown-out, which outranks all other causes.
module rcs_req_class
    import rcs_pkg::*;
(
    input  logic [NCAUSE-1:0] req,
    input  logic              clk_switch_en,
    output logic              go_por,
    output logic              go_bor,
    output logic              go_int,
    output logic              any_req,
    output logic              cfg_sel
);
    logic [NCAUSE-1:0] minor_chain;

    // OR-chain over the causes that only use the internal-state segment.
    genvar g;
    generate
        for (g = 0; g < NCAUSE; g++) begin : g_minor
            if (g < F_PIN) begin : g_skip
                assign minor_chain[g] = 1'b0;
            end else if (g == F_PIN) begin : g_first
                assign minor_chain[g] = req[g];
            end else begin : g_rest
                assign minor_chain[g] = minor_chain[g-1] | req[g];
            end
        end
    endgenerate

    // Priority decode and clock-source choice.
    always_comb begin
        go_por  = req[F_POR];
        go_bor  = req[F_BOR] & ~req[F_POR];
        go_int  = minor_chain[NCAUSE-1] & ~req[F_POR] & ~req[F_BOR];
        any_req = |req;
        cfg_sel = ~clk_switch_en | req[F_POR] | req[F_BOR];
    end
endmodule

// File: rtl/rcs_flag_bank.sv
// Sticky cause flags with per-flag set and clear events plus a software
// write port. Order inside one cycle: write, then hardware clears, then sets.
// Assumes: event inputs are single-cycle pulses synchronous to clk.
module rcs_flag_bank
    import rcs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCAUSE-1:0] req,
    input  logic              sleep_evt,
    input  logic              idle_evt,
    input  logic              wdt_clr_evt,
    input  logic              reg_we,
    input  logic [NFLAG-1:0]  reg_wdata,
    output logic [NFLAG-1:0]  flags
);
    logic [NFLAG-1:0] flags_q, base, clr, set, flags_d;

    // Next flag value from write data, clear events and set events.
    always_comb begin
        base = reg_we ? reg_wdata : flags_q;
        clr  = '0;
        if (req[F_POR]) clr = clr | POR_CLR_MASK;
        if (req[F_BOR]) clr = clr | BOR_CLR_MASK;
        if (sleep_evt | idle_evt | wdt_clr_evt) clr[F_WDT] = 1'b1;
        set  = {idle_evt, sleep_evt, req};
        flags_d = (base & ~clr) | set;
    end

    // Flag register; reset reflects a fresh power-on.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= NFLAG'(1) << F_POR;
        else        flags_q <= flags_d;
    end

    assign flags = flags_q;
endmodule

// File: rtl/rcs_delay_seq.sv
// Three-segment release timer: power-on, start-up, internal-state.
// A start input reloads the timer at the first segment of its class.
// Assumes: every segment length is at least one cycle.
module rcs_delay_seq
    import rcs_pkg::*;
#(
    parameter int POR_CYCLES   = 200,
    parameter int START_CYCLES = 1000,
    parameter int INT_CYCLES   = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go_por,
    input  logic go_bor,
    input  logic go_int,
    output logic in_reset
);
    localparam int MAXC = (POR_CYCLES > START_CYCLES)
                        ? ((POR_CYCLES > INT_CYCLES) ? POR_CYCLES : INT_CYCLES)
                        : ((START_CYCLES > INT_CYCLES) ? START_CYCLES : INT_CYCLES);
    localparam int CW = $clog2(MAXC + 1);
    localparam logic [CW-1:0] POR_LD   = CW'(POR_CYCLES - 1);
    localparam logic [CW-1:0] START_LD = CW'(START_CYCLES - 1);
    localparam logic [CW-1:0] INT_LD   = CW'(INT_CYCLES - 1);

    phase_e        phase;
    logic [CW-1:0] cnt;

    // Phase and down-counter: reload on a start, otherwise count and advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_POR;
            cnt   <= POR_LD;
        end else if (go_por) begin
            phase <= PH_POR;
            cnt   <= POR_LD;
        end else if (go_bor) begin
            phase <= PH_START;
            cnt   <= START_LD;
        end else if (go_int) begin
            phase <= PH_INT;
            cnt   <= INT_LD;
        end else if (phase != PH_RUN) begin
            if (cnt != '0) begin
                cnt <= cnt - 1'b1;
            end else begin
                case (phase)
                    PH_POR:   begin phase <= PH_START; cnt <= START_LD; end
                    PH_START: begin phase <= PH_INT;   cnt <= INT_LD;   end
                    default:  begin phase <= PH_RUN;   cnt <= '0;       end
                endcase
            end
        end
    end

    assign in_reset = (phase != PH_RUN);
endmodule

// File: rtl/rst_cause_seq.sv
// Top of the reset cause tracker: joins the request classifier, flag bank
// and release timer, and holds the clock-source choice of the last reset.
// Assumes: requests are synchronous to clk; supply detection is elsewhere.
module rst_cause_seq
    import rcs_pkg::*;
#(
    parameter int POR_CYCLES   = 200,
    parameter int START_CYCLES = 1000,
    parameter int INT_CYCLES   = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCAUSE-1:0] req_i,
    input  logic              sleep_evt,
    input  logic              idle_evt,
    input  logic              wdt_clr_evt,
    input  logic              clk_switch_en,
    input  logic              reg_we,
    input  logic [NFLAG-1:0]  reg_wdata,
    output logic [NFLAG-1:0]  reg_rdata,
    output logic              sys_rst,
    output logic              clk_from_cfg
);
    logic go_por, go_bor, go_int, any_req, cfg_sel;
    logic cfg_q;

    rcs_req_class u_class (
        .req           (req_i),
        .clk_switch_en (clk_switch_en),
        .go_por        (go_por),
        .go_bor        (go_bor),
        .go_int        (go_int),
        .any_req       (any_req),
        .cfg_sel       (cfg_sel)
    );

    rcs_flag_bank u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (req_i),
        .sleep_evt   (sleep_evt),
        .idle_evt    (idle_evt),
        .wdt_clr_evt (wdt_clr_evt),
        .reg_we      (reg_we),
        .reg_wdata   (reg_wdata),
        .flags       (reg_rdata)
    );

    rcs_delay_seq #(
        .POR_CYCLES   (POR_CYCLES),
        .START_CYCLES (START_CYCLES),
        .INT_CYCLES   (INT_CYCLES)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .go_por   (go_por),
        .go_bor   (go_bor),
        .go_int   (go_int),
        .in_reset (sys_rst)
    );

    // Clock-source choice, captured whenever any request is seen.
    always_ff @(posedge clk) begin
        if (!rst_n)       cfg_q <= 1'b1;
        else if (any_req) cfg_q <= cfg_sel;
    end

    assign clk_from_cfg = cfg_q;
endmodule

// File: rtl/rst_cause_seq_chk.sv
// Temporal checks on the reset cause tracker, attached by bind.
// Assumes: all inputs sampled at the rising edge of clk.
module rst_cause_seq_chk
    import rcs_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [NCAUSE-1:0] req_i,
    input logic              sleep_evt,
    input logic              idle_evt,
    input logic              wdt_clr_evt,
    input logic              reg_we,
    input logic [NFLAG-1:0]  reg_rdata,
    input logic              sys_rst,
    input logic              clk_from_cfg
);
    a_r2_req_raises_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_i) |=> sys_rst);

    a_r7_req_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_i) |=> ((reg_rdata[NCAUSE-1:0] & $past(req_i)) == $past(req_i)));

    a_r8_bor_keeps_pin: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i[F_BOR] && !req_i[F_POR] && !reg_we && reg_rdata[F_PIN])
        |=> reg_rdata[F_PIN]);

    a_r9_wdt_flag_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        ((sleep_evt || idle_evt || wdt_clr_evt) && !req_i[F_WDT])
        |=> !reg_rdata[F_WDT]);

    a_r10_write_no_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && (req_i == '0) && !sys_rst) |=> !sys_rst);

    a_r11_por_selects_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        req_i[F_POR] |=> clk_from_cfg);
endmodule

bind rst_cause_seq rst_cause_seq_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_i        (req_i),
    .sleep_evt    (sleep_evt),
    .idle_evt     (idle_evt),
    .wdt_clr_evt  (wdt_clr_evt),
    .reg_we       (reg_we),
    .reg_rdata    (reg_rdata),
    .sys_rst      (sys_rst),
    .clk_from_cfg (clk_from_cfg)
);

// File: tb/rst_cause_seq_test.sv
// Scoreboard bench: driver tasks queue the expected length of every
// sys_rst pulse, a monitor measures real pulses and compares.
module rst_cause_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int P = 5, S = 7, I = 4;
    localparam int T_POR = P + S + I;
    localparam int T_BOR = S + I;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  req_i = '0;
    logic        sleep_evt = 1'b0, idle_evt = 1'b0, wdt_clr_evt = 1'b0;
    logic        clk_switch_en = 1'b1;
    logic        reg_we = 1'b0;
    logic [10:0] reg_wdata = '0;
    logic [10:0] reg_rdata;
    logic        sys_rst, clk_from_cfg;

    int n_checks = 0, n_fail = 0;
    int    exp_len[$];
    string exp_tag[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    rst_cause_seq #(.POR_CYCLES(P), .START_CYCLES(S), .INT_CYCLES(I)) uut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .sleep_evt(sleep_evt),
        .idle_evt(idle_evt), .wdt_clr_evt(wdt_clr_evt),
        .clk_switch_en(clk_switch_en), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .sys_rst(sys_rst), .clk_from_cfg(clk_from_cfg)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Monitor: measure each sys_rst pulse after reset release and compare.
    initial begin : monitor
        int run;
        run = 0;
        forever begin
            @(negedge clk); #1;
            if (!rst_n) run = 0;
            else if (sys_rst) run++;
            else if (run > 0) begin
                if (exp_len.size() == 0) begin
                    check("unexpected sys_rst pulse", run, 0);
                end else begin
                    check(exp_tag.pop_front(), run, exp_len.pop_front());
                end
                run = 0;
            end
        end
    end

    // Watchdog: a hung run is counted as a failure.
    initial begin
        repeat (5000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    task automatic wait_release();
        do begin @(negedge clk); #1; end while (sys_rst);
        @(negedge clk); #1;
    endtask

    task automatic sw_write(input logic [10:0] v);
        @(negedge clk); reg_we = 1'b1; reg_wdata = v;
        @(negedge clk); reg_we = 1'b0; #1;
    endtask

    // Pulse a request for one cycle and queue its expected reset length.
    task automatic fire(input logic [8:0] v, input int len, input string tag);
        @(negedge clk); req_i = v;
        exp_len.push_back(len); exp_tag.push_back(tag);
        @(negedge clk); req_i = '0; #1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        exp_len.push_back(T_POR); exp_tag.push_back("R1 initial release length");
        rst_n = 1'b1; #1;
        check("R1 reset flags", reg_rdata, 11'h001);
        check("R1 reset clk_from_cfg", clk_from_cfg, 1);
        check("R1 reset sys_rst", sys_rst, 1);
        wait_release();

        // R10: writes change flags but never start a reset.
        sw_write(11'h000);
        check("R10 write zero", reg_rdata, 11'h000);
        sw_write(11'h7FC);
        check("R10 write pattern", reg_rdata, 11'h7FC);
        @(negedge clk); #1;
        check("R10 no reset after write", sys_rst, 0);

        // R2, R8: power-on clears bits 2..10 and sets bit 0.
        fire(9'h001, T_POR, "R2 power-on length");
        check("R8 power-on flags", reg_rdata, 11'h001);
        check("R11 power-on clk_from_cfg", clk_from_cfg, 1);
        wait_release();

        // R3, R8: brown-out keeps the pin flag.
        sw_write(11'h7FE);
        fire(9'h002, T_BOR, "R3 brown-out length");
        check("R8 brown-out keeps pin", reg_rdata, 11'h006);
        check("R11 brown-out clk_from_cfg", clk_from_cfg, 1);
        wait_release();

        // R4, R7, R11: every short cause.
        for (int k = 2; k < 9; k++) begin
            sw_write(11'h000);
            fire(9'(1 << k), I, "R4 short cause length");
            check("R7 cause flag position", reg_rdata, 1 << k);
            check("R11 short cause clk_from_cfg", clk_from_cfg, 0);
            wait_release();
        end

        // R9: watchdog flag clears and power-save sets.
        sw_write(11'h008);
        @(negedge clk); wdt_clr_evt = 1'b1; @(negedge clk); wdt_clr_evt = 1'b0; #1;
        check("R9 wdt clear event", reg_rdata, 11'h000);
        sw_write(11'h008);
        @(negedge clk); sleep_evt = 1'b1; @(negedge clk); sleep_evt = 1'b0; #1;
        check("R9 sleep sets and clears wdt", reg_rdata, 11'h200);
        sw_write(11'h008);
        @(negedge clk); idle_evt = 1'b1; @(negedge clk); idle_evt = 1'b0; #1;
        check("R9 idle sets and clears wdt", reg_rdata, 11'h400);

        // R10: hardware set wins over a same-cycle write.
        @(negedge clk); reg_we = 1'b1; reg_wdata = 11'h000; sleep_evt = 1'b1;
        @(negedge clk); reg_we = 1'b0; sleep_evt = 1'b0; #1;
        check("R10 set beats write", reg_rdata, 11'h200);

        // R11: clock switching disabled always selects configuration.
        clk_switch_en = 1'b0;
        fire(9'h010, I, "R4 software length");
        check("R11 switching off clk_from_cfg", clk_from_cfg, 1);
        wait_release();
        clk_switch_en = 1'b1;

        // R5: simultaneous requests take the longest class.
        sw_write(11'h000);
        fire(9'h005, T_POR, "R5 power-on plus pin length");
        check("R5 power-on plus pin flags", reg_rdata, 11'h005);
        wait_release();
        sw_write(11'h000);
        fire(9'h00A, T_BOR, "R5 brown-out plus watchdog length");
        check("R5 brown-out plus watchdog flags", reg_rdata, 11'h00A);
        wait_release();

        // R6: brown-out two cycles into a pin reset restarts at start-up.
        @(negedge clk); req_i = 9'h004;
        exp_len.push_back(2 + T_BOR); exp_tag.push_back("R6 restart length");
        @(negedge clk); req_i = '0;
        @(negedge clk); req_i = 9'h002;
        @(negedge clk); req_i = '0;
        wait_release();

        // R6: held pin request reloads every cycle.
        @(negedge clk); req_i = 9'h004;
        exp_len.push_back(2 + I); exp_tag.push_back("R6 held request length");
        repeat (3) @(negedge clk);
        req_i = '0;
        wait_release();

        repeat (3) @(negedge clk);
        check("R2 all expected pulses seen", exp_len.size(), 0);
        summary();
    end
endmodule